// File: doc/BRIEF.md
# Sparse Adaptive Decision-Feedback Tap Allocator

This block is the digital controller for a complex (I/Q) decision feedback equalizer that sees sparse post-cursor reflections. A fixed search window of past symbol delays is scanned. For every delay in the window, the block measures how strongly the current error correlates with the decision made that many symbols earlier. After each measurement window it places a small, fixed set of physical feedback taps on the strongest delays. Delays that carry no reflection get no tap, so they add no noise to the feedback.

Every symbol, each placed tap adapts a complex weight code with a sign-sign LMS rule. The block drives three things out to the analog current-steering feedback array: the delay index of each tap, its signed real and imaginary weight codes, and the past I and Q decision bits that the tap must steer. The block consumes one symbol per clock. Its inputs are the sliced decision bits and the error sign bits for both rails.

Top module: `dfe_sparse_alloc`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it, the tap slots hold delays 1 to NTAPS in slot order. All weights are zero and every history bit is 0.
- R2: Slot s outputs the I and Q decision bits that were applied k clock edges earlier, where k is the slot's delay. History taken from before reset reads as 0.
- R3: Let sg(1)=+1 and sg(0)=-1. At delay k, each symbol contributes a real term sg(eI)sg(dI)+sg(eQ)sg(dQ) and an imaginary term sg(eQ)sg(dI)-sg(eI)sg(dQ). Here d is the decision made k symbols earlier. The terms are summed over WIN_LEN consecutive symbols, and the delay's strength is |real sum|+|imag sum|.
- R4: At the end of each window, the NTAPS delays with the greatest strength are chosen, and an equal strength goes to the smaller delay. Slot 0 (tap_dly_o bits [3:0]) up to slot NTAPS-1 hold the chosen delays in strictly ascending order.
- R5: Windows start at the first edge after reset and last WIN_LEN edges. The new delays become visible after the edge that follows a window's last edge. That edge also counts as the first symbol of the next window.
- R6: Tap delays do not change at any other edge.
- R7: At each edge that does not reallocate, every slot's real weight moves by the sign of the real term at its delay (+1, -1, or 0 when the term is 0). The imaginary weight moves the same way. Weights are two's-complement WW-bit fields, and slot s is at bits [s*WW +: WW].
- R8: Weights saturate at -2^(WW-1) and 2^(WW-1)-1.
- R9: At a reallocation edge, no LMS step is applied. A delay that stays chosen carries its weight, moved to the slot where its delay now sits, and a newly chosen delay starts at weight 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_i_i | input | 1 | I-rail decision bit (1 = positive) |
| dec_q_i | input | 1 | Q-rail decision bit (1 = positive) |
| err_i_i | input | 1 | I-rail error sign (1 = positive) |
| err_q_i | input | 1 | Q-rail error sign (1 = positive) |
| tap_dly_o | output | NTAPS*DW | Delay index of each tap slot, slot 0 in the low bits |
| w_re_o | output | NTAPS*WW | Real weight code for each slot |
| w_im_o | output | NTAPS*WW | Imaginary weight code for each slot |
| tap_dec_i_o | output | NTAPS | Past I decision steered by each slot |
| tap_dec_q_o | output | NTAPS | Past Q decision steered by each slot |

## Verification
Some properties are checked on every cycle. The assertions check the history shift, the bound that each accumulator places on how many symbols it has seen, and that exactly NTAPS delays are ever chosen. They also check that delays stay strictly ascending and stay put between window ends, that weights move by at most one step, and that a delay entering the set starts at zero. Other behaviour can only be shown by the bench's scenarios. These are which delays win a given correlation pattern, how ties resolve, the exact edge at which weights saturate, and that a persistent delay keeps its value through reallocations. For these, the bench compares the outputs on every cycle with its own arithmetic model, under constant, single-reflection and random symbol streams.

// File: rtl/dfe_alloc_pkg.sv
package dfe_alloc_pkg;

  // map a sign bit to +1 / -1
  function automatic logic signed [2:0] pm1(input logic b);
    return b ? 3'sd1 : -3'sd1;
  endfunction

  // real part of err * conj(dec) in sign arithmetic
  function automatic logic signed [2:0] corr_re(input logic ei, input logic eq,
                                                input logic di, input logic dq);
    return pm1(ei ~^ di) + pm1(eq ~^ dq);
  endfunction

  // imaginary part of err * conj(dec) in sign arithmetic
  function automatic logic signed [2:0] corr_im(input logic ei, input logic eq,
                                                input logic di, input logic dq);
    return pm1(eq ~^ di) - pm1(ei ~^ dq);
  endfunction

  // sign of a correlation term as a -1/0/+1 step
  function automatic logic signed [1:0] step_of(input logic signed [2:0] v);
    if (v > 3'sd0) return 2'sd1;
    if (v < 3'sd0) return -2'sd1;
    return 2'sd0;
  endfunction

endpackage

// File: rtl/dfe_dec_hist.sv
module dfe_dec_hist #(
  parameter int DEPTH = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_i,
  input  logic             dec_q,
  output logic [DEPTH:1]   hist_i,
  output logic [DEPTH:1]   hist_q
);
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_i <= '0;
      hist_q <= '0;
      live   <= 1'b0;
    end else begin
      hist_i <= {hist_i[DEPTH-1:1], dec_i};
      hist_q <= {hist_q[DEPTH-1:1], dec_q};
      live   <= 1'b1;
    end
  end

  // R2
  hist_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (hist_i[1] == $past(dec_i) && hist_q[1] == $past(dec_q)));

  for (genvar k = 2; k <= DEPTH; k++) begin : g_age
    // R2
    hist_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> (hist_i[k] == $past(hist_i[k-1]) && hist_q[k] == $past(hist_q[k-1])));
  end
endmodule

// File: rtl/dfe_corr_bank.sv
module dfe_corr_bank
  import dfe_alloc_pkg::*;
#(
  parameter int DEPTH   = 14,
  parameter int WIN_LEN = 1024,
  parameter int AW      = $clog2(WIN_LEN) + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    err_i,
  input  logic                    err_q,
  input  logic [DEPTH:1]          hist_i,
  input  logic [DEPTH:1]          hist_q,
  output logic [DEPTH:1][2:0]     p_re,
  output logic [DEPTH:1][2:0]     p_im,
  output logic [DEPTH:1][AW-1:0]  metric,
  output logic                    snap_v
);
  localparam int CW = $clog2(WIN_LEN);

  logic [CW-1:0]          cnt;
  logic                   win_end;
  logic [DEPTH:1][AW-1:0] acc_re;
  logic [DEPTH:1][AW-1:0] acc_im;
  logic [DEPTH:1][AW-1:0] sum_re;
  logic [DEPTH:1][AW-1:0] sum_im;

  function automatic logic [AW-1:0] mag(input logic [AW-1:0] v);
    return v[AW-1] ? (~v + 1'b1) : v;
  endfunction

  assign win_end = (cnt == CW'(WIN_LEN - 1));

  always_comb begin
    for (int k = 1; k <= DEPTH; k++) begin
      p_re[k]   = corr_re(err_i, err_q, hist_i[k], hist_q[k]);
      p_im[k]   = corr_im(err_i, err_q, hist_i[k], hist_q[k]);
      sum_re[k] = acc_re[k] + {{(AW-3){p_re[k][2]}}, p_re[k]};
      sum_im[k] = acc_im[k] + {{(AW-3){p_im[k][2]}}, p_im[k]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      acc_re <= '0;
      acc_im <= '0;
      metric <= '0;
      snap_v <= 1'b0;
    end else begin
      snap_v <= win_end;
      if (win_end) begin
        cnt    <= '0;
        acc_re <= '0;
        acc_im <= '0;
        for (int k = 1; k <= DEPTH; k++)
          metric[k] <= mag(sum_re[k]) + mag(sum_im[k]);
      end else begin
        cnt    <= cnt + 1'b1;
        acc_re <= sum_re;
        acc_im <= sum_im;
      end
    end
  end

  // R5
  snap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_v |=> !snap_v);

  for (genvar k = 1; k <= DEPTH; k++) begin : g_bound
    // R3
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(mag(acc_re[k])) <= 2 * int'(cnt)) && (int'(mag(acc_im[k])) <= 2 * int'(cnt)));
  end
endmodule

// File: rtl/dfe_tap_picker.sv
module dfe_tap_picker #(
  parameter int DEPTH = 14,
  parameter int NTAPS = 5,
  parameter int MW    = 13,
  parameter int DW    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DEPTH:1][MW-1:0]  metric,
  output logic [NTAPS-1:0][DW-1:0] sel_dly
);
  logic [DEPTH:1] sel_mask;

  // rank each delay: count delays that beat it (stronger, or equal and smaller)
  always_comb begin
    for (int k = 1; k <= DEPTH; k++) begin
      int beaten;
      beaten = 0;
      for (int j = 1; j <= DEPTH; j++) begin
        if (j != k) begin
          if ((metric[j] > metric[k]) || ((metric[j] == metric[k]) && (j < k)))
            beaten = beaten + 1;
        end
      end
      sel_mask[k] = (beaten < NTAPS);
    end
  end

  // compact the chosen delays into ascending slots
  always_comb begin
    int slot;
    slot    = 0;
    sel_dly = '0;
    for (int k = 1; k <= DEPTH; k++) begin
      if (sel_mask[k]) begin
        for (int s = 0; s < NTAPS; s++)
          if (slot == s) sel_dly[s] = DW'(k);
        slot = slot + 1;
      end
    end
  end

  // R4
  sel_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_mask) == NTAPS);
endmodule

// File: rtl/dfe_tap_weights.sv
module dfe_tap_weights
  import dfe_alloc_pkg::*;
#(
  parameter int DEPTH = 14,
  parameter int NTAPS = 5,
  parameter int WW    = 5,
  parameter int DW    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     snap_v,
  input  logic [NTAPS-1:0][DW-1:0] sel_dly,
  input  logic [DEPTH:1][2:0]      p_re,
  input  logic [DEPTH:1][2:0]      p_im,
  output logic [NTAPS-1:0][DW-1:0] pos,
  output logic [NTAPS-1:0][WW-1:0] w_re,
  output logic [NTAPS-1:0][WW-1:0] w_im
);
  localparam int WMAX = (1 <<< (WW - 1)) - 1;
  localparam int WMIN = -(1 <<< (WW - 1));

  logic [NTAPS-1:0][WW-1:0] lms_re, lms_im;
  logic [NTAPS-1:0][WW-1:0] carry_re, carry_im;

  function automatic logic [WW-1:0] sat_step(input logic [WW-1:0] w,
                                             input logic signed [1:0] st);
    int v;
    v = int'($signed(w)) + int'(st);
    if (v > WMAX) v = WMAX;
    if (v < WMIN) v = WMIN;
    return WW'(v);
  endfunction

  function automatic logic in_set(input logic [DW-1:0] d,
                                  input logic [NTAPS-1:0][DW-1:0] set);
    logic hit;
    hit = 1'b0;
    for (int t = 0; t < NTAPS; t++) if (set[t] == d) hit = 1'b1;
    return hit;
  endfunction

  // per-slot LMS update and weight carry-over for kept delays
  always_comb begin
    for (int s = 0; s < NTAPS; s++) begin
      lms_re[s]   = sat_step(w_re[s], step_of($signed(p_re[pos[s]])));
      lms_im[s]   = sat_step(w_im[s], step_of($signed(p_im[pos[s]])));
      carry_re[s] = '0;
      carry_im[s] = '0;
      for (int t = 0; t < NTAPS; t++) begin
        if (pos[t] == sel_dly[s]) begin
          carry_re[s] = w_re[t];
          carry_im[s] = w_im[t];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NTAPS; s++) pos[s] <= DW'(s + 1);
      w_re <= '0;
      w_im <= '0;
    end else if (snap_v) begin
      pos  <= sel_dly;
      w_re <= carry_re;
      w_im <= carry_im;
    end else begin
      w_re <= lms_re;
      w_im <= lms_im;
    end
  end

  // R6
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_v |=> $stable(pos));

  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos[0] >= DW'(1)) && (pos[NTAPS-1] <= DW'(DEPTH)));

  for (genvar s = 0; s < NTAPS; s++) begin : g_slot
    if (s < NTAPS - 1) begin : g_ord
      // R4
      pos_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos[s] < pos[s+1]);
    end
    // R7
    w_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_v |=> ((int'($signed(w_re[s])) - int'($signed($past(w_re[s])))) <= 1 &&
                   (int'($signed(w_re[s])) - int'($signed($past(w_re[s])))) >= -1 &&
                   (int'($signed(w_im[s])) - int'($signed($past(w_im[s])))) <= 1 &&
                   (int'($signed(w_im[s])) - int'($signed($past(w_im[s])))) >= -1));
    // R9
    new_tap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_v |=> (in_set(pos[s], $past(pos)) || (w_re[s] == '0 && w_im[s] == '0)));
  end
endmodule

// File: rtl/dfe_sparse_alloc.sv
module dfe_sparse_alloc #(
  parameter int DEPTH   = 14,
  parameter int NTAPS   = 5,
  parameter int WW      = 5,
  parameter int WIN_LEN = 1024,
  parameter int DW      = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dec_i_i,
  input  logic                dec_q_i,
  input  logic                err_i_i,
  input  logic                err_q_i,
  output logic [NTAPS*DW-1:0] tap_dly_o,
  output logic [NTAPS*WW-1:0] w_re_o,
  output logic [NTAPS*WW-1:0] w_im_o,
  output logic [NTAPS-1:0]    tap_dec_i_o,
  output logic [NTAPS-1:0]    tap_dec_q_o
);
  localparam int AW = $clog2(WIN_LEN) + 3;

  logic [DEPTH:1]           hist_i, hist_q;
  logic [DEPTH:1][2:0]      p_re, p_im;
  logic [DEPTH:1][AW-1:0]   metric;
  logic                     snap_v;
  logic [NTAPS-1:0][DW-1:0] sel_dly;
  logic [NTAPS-1:0][DW-1:0] pos;
  logic [NTAPS-1:0][WW-1:0] w_re, w_im;

  dfe_dec_hist #(.DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n), .dec_i(dec_i_i), .dec_q(dec_q_i),
    .hist_i(hist_i), .hist_q(hist_q)
  );

  dfe_corr_bank #(.DEPTH(DEPTH), .WIN_LEN(WIN_LEN), .AW(AW)) u_corr (
    .clk(clk), .rst_n(rst_n), .err_i(err_i_i), .err_q(err_q_i),
    .hist_i(hist_i), .hist_q(hist_q), .p_re(p_re), .p_im(p_im),
    .metric(metric), .snap_v(snap_v)
  );

  dfe_tap_picker #(.DEPTH(DEPTH), .NTAPS(NTAPS), .MW(AW), .DW(DW)) u_pick (
    .clk(clk), .rst_n(rst_n), .metric(metric), .sel_dly(sel_dly)
  );

  dfe_tap_weights #(.DEPTH(DEPTH), .NTAPS(NTAPS), .WW(WW), .DW(DW)) u_wts (
    .clk(clk), .rst_n(rst_n), .snap_v(snap_v), .sel_dly(sel_dly),
    .p_re(p_re), .p_im(p_im), .pos(pos), .w_re(w_re), .w_im(w_im)
  );

  assign tap_dly_o = pos;
  assign w_re_o    = w_re;
  assign w_im_o    = w_im;

  always_comb begin
    for (int s = 0; s < NTAPS; s++) begin
      tap_dec_i_o[s] = hist_i[pos[s]];
      tap_dec_q_o[s] = hist_q[pos[s]];
    end
  end
endmodule

// File: tb/sim_dfe_sparse_alloc.sv
`timescale 1ns/1ps
module sim_dfe_sparse_alloc;
  localparam int DEPTH = 14;
  localparam int NTAPS = 5;
  localparam int WW    = 5;
  localparam int DW    = 4;
  localparam int WIN   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic di = 0, dq = 0, ei = 0, eq = 0;
  logic [NTAPS*DW-1:0] tap_dly_o;
  logic [NTAPS*WW-1:0] w_re_o, w_im_o;
  logic [NTAPS-1:0]    tap_dec_i_o, tap_dec_q_o;

  always #2.5 clk = ~clk;

  dfe_sparse_alloc #(.DEPTH(DEPTH), .NTAPS(NTAPS), .WW(WW), .WIN_LEN(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .dec_i_i(di), .dec_q_i(dq), .err_i_i(ei), .err_q_i(eq),
    .tap_dly_o(tap_dly_o), .w_re_o(w_re_o), .w_im_o(w_im_o),
    .tap_dec_i_o(tap_dec_i_o), .tap_dec_q_o(tap_dec_q_o)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  int m_hi[1:DEPTH], m_hq[1:DEPTH];
  int m_are[1:DEPTH], m_aim[1:DEPTH], m_snap[1:DEPTH];
  int m_cnt, m_pend;
  int m_pos[NTAPS], m_wre[NTAPS], m_wim[NTAPS];
  logic [15:0] lfsr = 16'hACE1;

  function automatic int sg(input int b);
    return (b != 0) ? 1 : -1;
  endfunction
  function automatic int sgn(input int v);
    return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
  endfunction
  function automatic int clampw(input int v);
    if (v > 15) return 15;
    if (v < -16) return -16;
    return v;
  endfunction
  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic model_reset();
    for (int k = 1; k <= DEPTH; k++) begin
      m_hi[k] = 0; m_hq[k] = 0; m_are[k] = 0; m_aim[k] = 0; m_snap[k] = 0;
    end
    m_cnt = 0; m_pend = 0;
    for (int s = 0; s < NTAPS; s++) begin m_pos[s] = s + 1; m_wre[s] = 0; m_wim[s] = 0; end
  endtask

  task automatic model_edge(input int xdi, input int xdq, input int xei, input int xeq);
    int pr[1:DEPTH];
    int pi[1:DEPTH];
    int npos[NTAPS];
    int nre[NTAPS];
    int nim[NTAPS];
    bit taken[1:DEPTH];
    int n;
    for (int k = 1; k <= DEPTH; k++) begin
      pr[k] = sg(xei) * sg(m_hi[k]) + sg(xeq) * sg(m_hq[k]);
      pi[k] = sg(xeq) * sg(m_hi[k]) - sg(xei) * sg(m_hq[k]);
      taken[k] = 0;
    end
    if (m_pend != 0) begin
      for (int r = 0; r < NTAPS; r++) begin
        int best;
        best = -1;
        for (int k = 1; k <= DEPTH; k++)
          if (!taken[k] && (best < 0 || m_snap[k] > m_snap[best])) best = k;
        taken[best] = 1;
      end
      n = 0;
      for (int k = 1; k <= DEPTH; k++) if (taken[k]) begin npos[n] = k; n++; end
      for (int s = 0; s < NTAPS; s++) begin
        nre[s] = 0; nim[s] = 0;
        for (int t = 0; t < NTAPS; t++)
          if (m_pos[t] == npos[s]) begin nre[s] = m_wre[t]; nim[s] = m_wim[t]; end
      end
      for (int s = 0; s < NTAPS; s++) begin m_pos[s] = npos[s]; m_wre[s] = nre[s]; m_wim[s] = nim[s]; end
    end else begin
      for (int s = 0; s < NTAPS; s++) begin
        m_wre[s] = clampw(m_wre[s] + sgn(pr[m_pos[s]]));
        m_wim[s] = clampw(m_wim[s] + sgn(pi[m_pos[s]]));
      end
    end
    if (m_cnt == WIN - 1) begin
      for (int k = 1; k <= DEPTH; k++) begin
        m_snap[k] = iabs(m_are[k] + pr[k]) + iabs(m_aim[k] + pi[k]);
        m_are[k] = 0; m_aim[k] = 0;
      end
      m_cnt = 0; m_pend = 1;
    end else begin
      for (int k = 1; k <= DEPTH; k++) begin m_are[k] += pr[k]; m_aim[k] += pi[k]; end
      m_cnt++; m_pend = 0;
    end
    for (int k = DEPTH; k >= 2; k--) begin m_hi[k] = m_hi[k-1]; m_hq[k] = m_hq[k-1]; end
    m_hi[1] = xdi; m_hq[1] = xdq;
  endtask

  task automatic check(input bit ok, input string what, input string got, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %s expected %s", what, got, exp);
    end
  endtask

  function automatic string exp_pos_str();
    string r;
    r = "";
    for (int s = NTAPS - 1; s >= 0; s--) r = {r, $sformatf("%0d ", m_pos[s])};
    return r;
  endfunction

  task automatic compare_all();
    bit okp, okw, okd;
    okp = 1; okw = 1; okd = 1;
    for (int s = 0; s < NTAPS; s++) begin
      if (int'(tap_dly_o[s*DW +: DW]) != m_pos[s]) okp = 0;
      if (int'($signed(w_re_o[s*WW +: WW])) != m_wre[s]) okw = 0;
      if (int'($signed(w_im_o[s*WW +: WW])) != m_wim[s]) okw = 0;
      if (int'(tap_dec_i_o[s]) != m_hi[m_pos[s]]) okd = 0;
      if (int'(tap_dec_q_o[s]) != m_hq[m_pos[s]]) okd = 0;
    end
    // R3 R4 R5 R6: delays chosen from window strengths, at the right edge
    check(okp, "R3 R4 R5 R6 tap delays", $sformatf("%h", tap_dly_o), exp_pos_str());
    // R7 R8 R9: weight evolution
    check(okw, "R7 R8 R9 weights", $sformatf("%h/%h", w_re_o, w_im_o),
          $sformatf("slot0 %0d/%0d", m_wre[0], m_wim[0]));
    // R2: steered past decisions
    check(okd, "R2 tap decisions", $sformatf("%b/%b", tap_dec_i_o, tap_dec_q_o), "model history");
  endtask

  task automatic sym(input int xdi, input int xdq, input int xei, input int xeq);
    di = xdi[0]; dq = xdq[0]; ei = xei[0]; eq = xeq[0];
    @(posedge clk);
    model_edge(xdi, xdq, xei, xeq);
    @(negedge clk);
    compare_all();
  endtask

  function automatic int next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr[0]);
  endfunction

  function automatic int slot_of(input int d);
    for (int s = 0; s < NTAPS; s++) if (int'(tap_dly_o[s*DW +: DW]) == d) return s;
    return -1;
  endfunction

  initial begin
    int sl;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    begin
      bit ok;
      ok = (w_re_o == '0) && (w_im_o == '0) && (tap_dec_i_o == '0) && (tap_dec_q_o == '0);
      for (int s = 0; s < NTAPS; s++) if (int'(tap_dly_o[s*DW +: DW]) != s + 1) ok = 0;
      check(ok, "R1 reset state", $sformatf("%h %h %h", tap_dly_o, w_re_o, w_im_o), "5 4 3 2 1 / 0 / 0");
    end
    rst_n = 1'b1;
    compare_all();

    // constant positive decisions and errors: all delays tie, real weights climb
    for (int i = 0; i < 3 * WIN; i++) sym(1, 1, 1, 1);
    // R8: upper saturation
    check($signed(w_re_o[0 +: WW]) == 15, "R8 upper clamp", $sformatf("%0d", $signed(w_re_o[0 +: WW])), "15");
    // R4: ties resolve toward smaller delays
    check(tap_dly_o == {4'd5, 4'd4, 4'd3, 4'd2, 4'd1}, "R4 tie order", $sformatf("%h", tap_dly_o), "54321");

    // decisions positive, errors negative: weights fall to the floor
    for (int i = 0; i < 3 * WIN; i++) sym(1, 1, 0, 0);
    // R8: lower saturation
    check($signed(w_re_o[0 +: WW]) == -16, "R8 lower clamp", $sformatf("%0d", $signed(w_re_o[0 +: WW])), "-16");

    // single reflection at delay 9: error equals the decision nine symbols back
    for (int i = 0; i < 5 * WIN; i++) begin
      int a, b;
      a = next_bit(); b = next_bit();
      sym(a, b, m_hi[9], m_hq[9]);
    end
    sl = slot_of(9);
    // R4: the reflected delay is chosen
    check(sl >= 0, "R4 reflection found", $sformatf("%h", tap_dly_o), "delay 9 present");
    // R9: kept delay keeps its saturated weight across reallocations
    if (sl >= 0)
      check($signed(w_re_o[sl*WW +: WW]) == 15 && w_im_o[sl*WW +: WW] == '0, "R9 kept weight",
            $sformatf("%0d/%0d", $signed(w_re_o[sl*WW +: WW]), $signed(w_im_o[sl*WW +: WW])), "15/0");

    // fully random stream: frequent reallocations
    for (int i = 0; i < 20 * WIN; i++) begin
      int a, b, c, d;
      a = next_bit(); b = next_bit(); c = next_bit(); d = next_bit();
      sym(a, b, c, d);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule